// File: doc/BRIEF.md
# Fixed Off-Time Current Chopping Controller

This block keeps a motor winding's current in a band by chopping the high-side drive at a fixed off time. An on period starts with the source-enable latch set. When the current-sense comparator reports that the trip level has been reached, the latch clears and an off period of a fixed length starts. Inside the off period, a two-bit decay selector sets how the winding current recirculates. It can use fast decay with both drivers released, slow decay with the low-side drivers shorting the winding, or a split that runs fast decay first and then slow decay.

Every off period is followed by a blanking window that masks the comparator. This stops the reverse-recovery spike at switch-on from tripping the latch again. The window has one of two selectable lengths. It also restarts whenever the direction input changes or the external enable input changes in either direction.

When synchronous rectification is allowed, a gate request is raised during decay. Once a zero-current detect input is seen, that request is withdrawn until the next off period, so the winding current cannot reverse. The comparator and zero-detect inputs are asynchronous and are synchronised inside the block. All counting is done in cycles of the oscillator clock.

Top module: `offtime_chopper`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the block is in blanking with `srcLatch`=1, `decayFast`=0, `decaySlow`=0 and `srGate`=0.
- R2: A comparator trip seen during an on period clears `srcLatch` and starts an off period of exactly 96 clock cycles. In every one of those cycles exactly one of `decayFast` or `decaySlow` is 1, and `srcLatch` is 0.
- R3: The off period opens with a run of `decayFast` cycles whose length depends on `decaySel`: 0 for 2'b00, 14 for 2'b01, 46 for 2'b10 and 96 for 2'b11. The rest of the 96 cycles are `decaySlow`, and fast decay never follows slow decay within one off period.
- R4: `decayFast`, `decaySlow` and `blanking` are never 1 at the same time as one another.
- R5: Each off period ends directly in blanking. Blanking lasts 6 cycles when `blankLong`=0 and 12 cycles when `blankLong`=1, with `srcLatch`=1 throughout. After that an on period starts with `srcLatch`=1.
- R6: A comparator trip that rises and falls while blanking is active has no effect. A trip that is still present in the last blanking cycle starts an off period in the very next cycle.
- R7: A change of `dirIn`, or any edge on `enableIn`, restarts blanking from its first cycle. The restart takes effect in the cycle after the change, from any state, including the middle of an off period.
- R8: `srGate` is 1 only during off cycles with `srEn`=1. Once `zeroDetect` has been seen during an off period, `srGate` stays 0 until the next off period begins.
- R9: `srcDrive` equals `srcLatch` while `enableIn`=1 and is 0 while `enableIn`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| senseTrip | input | 1 | Current-sense comparator output, asynchronous |
| zeroDetect | input | 1 | Zero-current detect, asynchronous |
| dirIn | input | 1 | Commutation direction |
| enableIn | input | 1 | External enable / external PWM |
| decaySel | input | 2 | Decay selection (00 slow, 01 14-count fast, 10 46-count fast, 11 fast) |
| blankLong | input | 1 | 0: 6-cycle blanking, 1: 12-cycle blanking |
| srEn | input | 1 | Allow synchronous rectification |
| srcLatch | output | 1 | Source-enable latch state |
| srcDrive | output | 1 | High-side drive request (latch gated by enable) |
| decayFast | output | 1 | Fast-decay recirculation active |
| decaySlow | output | 1 | Slow-decay recirculation active (low sides on) |
| blanking | output | 1 | Comparator blanking window active |
| srGate | output | 1 | Synchronous-rectification gate request |

## Verification
Chop cycles are run with each of the four decay selections, and the lengths of the fast, slow and blanking runs are counted. This tells apart the four split points and confirms that the two phases always add up to the fixed off time. Comparator pulses are placed inside the blanking window and also held across its end, which separates a correctly masked trip from one that is late or lost. Direction and enable edges are applied during the on period, during blanking and during decay, to show that the restart works from every state. Zero-detect pulses with rectification allowed and with it forbidden show that the gate request stays withdrawn once dropped and is released again at the next off period.

// File: rtl/offtime_chopper_pkg.sv
package offtime_chopper_pkg;

  typedef enum logic [1:0] {
    ST_ON       = 2'd0,
    ST_OFF_FAST = 2'd1,
    ST_OFF_SLOW = 2'd2,
    ST_BLANK    = 2'd3
  } chop_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic zeroClr;
  } ctrl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic trip;
    logic restart;
    logic fastNone;
    logic fastEnd;
    logic offEnd;
    logic blankEnd;
    logic zeroSeen;
  } dp_status_t;

endpackage

// File: rtl/offtime_chopper_dp.sv
module offtime_chopper_dp
  import offtime_chopper_pkg::*;
#(
  parameter int OFF_LEN     = 96,
  parameter int FAST_LO     = 14,
  parameter int FAST_HI     = 46,
  parameter int BLANK_SHORT = 6,
  parameter int BLANK_LONG  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         senseTrip,
  input  logic         zeroDetect,
  input  logic         dirIn,
  input  logic         enableIn,
  input  logic [1:0]   decaySel,
  input  logic         blankLong,
  input  ctrl_strobe_t strobe,
  output dp_status_t   status
);

  localparam int CNT_W = $clog2(OFF_LEN + 1);

  logic [SYNC_STAGES-1:0] tripSync;
  logic [SYNC_STAGES-1:0] zeroSync;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tripSync[g] <= 1'b0;
          zeroSync[g] <= 1'b0;
        end else if (g == 0) begin
          tripSync[g] <= senseTrip;
          zeroSync[g] <= zeroDetect;
        end else begin
          tripSync[g] <= tripSync[(g == 0) ? 0 : g-1];
          zeroSync[g] <= zeroSync[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] fastLen;
  logic [CNT_W-1:0] blankLen;
  logic             dirPrev;
  logic             enPrev;
  logic             zeroSeen;

  always_comb begin
    case (decaySel)
      2'b00:   fastLen = '0;
      2'b01:   fastLen = CNT_W'(FAST_LO);
      2'b10:   fastLen = CNT_W'(FAST_HI);
      default: fastLen = CNT_W'(OFF_LEN);
    endcase
    blankLen = blankLong ? CNT_W'(BLANK_LONG) : CNT_W'(BLANK_SHORT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      dirPrev  <= 1'b0;
      enPrev   <= 1'b1;
      zeroSeen <= 1'b0;
    end else begin
      dirPrev <= dirIn;
      enPrev  <= enableIn;
      if (strobe.cntClr)     cnt <= '0;
      else if (strobe.cntEn) cnt <= cnt + 1'b1;
      if (strobe.zeroClr)              zeroSeen <= 1'b0;
      else if (zeroSync[SYNC_STAGES-1]) zeroSeen <= 1'b1;
    end
  end

  assign status.trip     = tripSync[SYNC_STAGES-1];
  assign status.restart  = (dirIn != dirPrev) || (enableIn != enPrev);
  assign status.fastNone = (fastLen == '0);
  assign status.fastEnd  = (cnt == fastLen - 1'b1);
  assign status.offEnd   = (cnt == CNT_W'(OFF_LEN - 1));
  assign status.blankEnd = (cnt == blankLen - 1'b1);
  assign status.zeroSeen = zeroSeen;

endmodule

// File: rtl/offtime_chopper_ctrl.sv
module offtime_chopper_ctrl
  import offtime_chopper_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dp_status_t   status,
  input  logic         srEn,
  input  logic         enableIn,
  output ctrl_strobe_t strobe,
  output logic         srcLatch,
  output logic         srcDrive,
  output logic         decayFast,
  output logic         decaySlow,
  output logic         blanking,
  output logic         srGate
);

  chop_state_t stateQ, stateD;

  always_comb begin
    stateD         = stateQ;
    strobe.cntClr  = 1'b0;
    strobe.cntEn   = 1'b1;
    strobe.zeroClr = 1'b0;
    if (status.restart) begin
      stateD        = ST_BLANK;
      strobe.cntClr = 1'b1;
    end else begin
      case (stateQ)
        ST_ON: begin
          strobe.cntEn = 1'b0;
          if (status.trip) begin
            stateD         = status.fastNone ? ST_OFF_SLOW : ST_OFF_FAST;
            strobe.cntClr  = 1'b1;
            strobe.zeroClr = 1'b1;
          end
        end
        ST_OFF_FAST: begin
          if (status.offEnd) begin
            stateD        = ST_BLANK;
            strobe.cntClr = 1'b1;
          end else if (status.fastEnd) begin
            stateD = ST_OFF_SLOW;
          end
        end
        ST_OFF_SLOW: begin
          if (status.offEnd) begin
            stateD        = ST_BLANK;
            strobe.cntClr = 1'b1;
          end
        end
        default: begin
          if (status.blankEnd) begin
            strobe.cntClr = 1'b1;
            if (status.trip) begin
              stateD         = status.fastNone ? ST_OFF_SLOW : ST_OFF_FAST;
              strobe.zeroClr = 1'b1;
            end else begin
              stateD = ST_ON;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_BLANK;
    else       stateQ <= stateD;
  end

  assign decayFast = (stateQ == ST_OFF_FAST);
  assign decaySlow = (stateQ == ST_OFF_SLOW);
  assign blanking  = (stateQ == ST_BLANK);
  assign srcLatch  = (stateQ == ST_ON) || (stateQ == ST_BLANK);
  assign srcDrive  = srcLatch && enableIn;
  assign srGate    = srEn && (decayFast || decaySlow) && !status.zeroSeen;

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import offtime_chopper_pkg::*;
#(
  parameter int OFF_LEN     = 96,
  parameter int FAST_LO     = 14,
  parameter int FAST_HI     = 46,
  parameter int BLANK_SHORT = 6,
  parameter int BLANK_LONG  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       senseTrip,
  input  logic       zeroDetect,
  input  logic       dirIn,
  input  logic       enableIn,
  input  logic [1:0] decaySel,
  input  logic       blankLong,
  input  logic       srEn,
  output logic       srcLatch,
  output logic       srcDrive,
  output logic       decayFast,
  output logic       decaySlow,
  output logic       blanking,
  output logic       srGate
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  offtime_chopper_dp #(
    .OFF_LEN(OFF_LEN), .FAST_LO(FAST_LO), .FAST_HI(FAST_HI),
    .BLANK_SHORT(BLANK_SHORT), .BLANK_LONG(BLANK_LONG),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .senseTrip(senseTrip), .zeroDetect(zeroDetect),
    .dirIn(dirIn), .enableIn(enableIn), .decaySel(decaySel),
    .blankLong(blankLong), .strobe(strobe), .status(status)
  );

  offtime_chopper_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .status(status), .srEn(srEn),
    .enableIn(enableIn), .strobe(strobe), .srcLatch(srcLatch),
    .srcDrive(srcDrive), .decayFast(decayFast), .decaySlow(decaySlow),
    .blanking(blanking), .srGate(srGate)
  );

endmodule

// File: rtl/offtime_chopper_chk.sv
module offtime_chopper_chk #(
  parameter int OFF_LEN = 96
) (
  input logic clk,
  input logic rstN,
  input logic srEn,
  input logic srcLatch,
  input logic decayFast,
  input logic decaySlow,
  input logic blanking,
  input logic srGate
);

  int offRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      offRun <= 0;
    else if (decayFast || decaySlow) offRun <= offRun + 1;
    else                            offRun <= 0;
  end

  assert_off_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    offRun <= OFF_LEN);

  assert_latch_low_in_decay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (decayFast || decaySlow) |-> !srcLatch);

  assert_no_fast_after_slow_R3: assert property (@(posedge clk) disable iff (!rstN)
    decaySlow |=> !decayFast);

  assert_phases_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({decayFast, decaySlow, blanking}));

  assert_off_ends_in_blank_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(decayFast || decaySlow) |-> blanking);

  assert_sr_only_in_decay_R8: assert property (@(posedge clk) disable iff (!rstN)
    srGate |-> (srEn && (decayFast || decaySlow)));

endmodule

bind offtime_chopper offtime_chopper_chk #(.OFF_LEN(OFF_LEN)) chk_i (
  .clk(clk), .rstN(rstN), .srEn(srEn), .srcLatch(srcLatch),
  .decayFast(decayFast), .decaySlow(decaySlow), .blanking(blanking),
  .srGate(srGate)
);

// File: tb/offtime_chopper_tb_top.sv
`timescale 1ns/1ps
module offtime_chopper_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic senseTrip = 1'b0, zeroDetect = 1'b0, dirIn = 1'b0, enableIn = 1'b1;
  logic [1:0] decaySel = 2'b00;
  logic blankLong = 1'b0, srEn = 1'b0;
  logic srcLatch, srcDrive, decayFast, decaySlow, blanking, srGate;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  offtime_chopper dut_i (
    .clk(clk), .rstN(rstN), .senseTrip(senseTrip), .zeroDetect(zeroDetect),
    .dirIn(dirIn), .enableIn(enableIn), .decaySel(decaySel),
    .blankLong(blankLong), .srEn(srEn), .srcLatch(srcLatch),
    .srcDrive(srcDrive), .decayFast(decayFast), .decaySlow(decaySlow),
    .blanking(blanking), .srGate(srGate)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitOn();
    for (int i = 0; i < 300; i++) begin
      if (srcLatch && !blanking) return;
      @(negedge clk);
    end
    check("waitOn", 0, 1);
  endtask

  task automatic waitOff();
    for (int i = 0; i < 20; i++) begin
      if (decayFast || decaySlow) return;
      @(negedge clk);
    end
    check("waitOff", 0, 1);
  endtask

  task automatic countFast(output int n);
    n = 0;
    while (decayFast && n < 500) begin n++; @(negedge clk); end
  endtask
  task automatic countSlow(output int n);
    n = 0;
    while (decaySlow && n < 500) begin n++; @(negedge clk); end
  endtask
  task automatic countBlank(output int n);
    n = 0;
    while (blanking && n < 500) begin n++; @(negedge clk); end
  endtask

  // R1
  task automatic testReset();
    check("R1 blanking", blanking, 1);
    check("R1 srcLatch", srcLatch, 1);
    check("R1 decay", decayFast | decaySlow, 0);
    check("R1 srGate", srGate, 0);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 after release blanking", blanking, 1);
    begin
      int n;
      countBlank(n);
      check("R5 reset blank length", n, 6);
    end
  endtask

  // R2 R3 R5
  task automatic testChop(input logic [1:0] sel, input int expFast, input bit longB);
    int nf, ns, nb;
    decaySel = sel;
    blankLong = longB;
    waitOn();
    senseTrip = 1'b1;
    waitOff();
    senseTrip = 1'b0;
    check("R2 latch cleared", srcLatch, 0);
    countFast(nf);
    countSlow(ns);
    check("R3 fast count", nf, expFast);
    check("R2 off total", nf + ns, 96);
    check("R5 blank after off", blanking, 1);
    countBlank(nb);
    check("R5 blank length", nb, longB ? 12 : 6);
    check("R5 on after blank", srcLatch && !blanking && !decayFast && !decaySlow, 1);
  endtask

  // R6
  task automatic testBlankIgnore();
    int nb;
    decaySel = 2'b00;
    blankLong = 1'b1;
    waitOn();
    senseTrip = 1'b1;
    waitOff();
    senseTrip = 1'b0;
    while (!blanking) @(negedge clk);
    @(negedge clk);
    senseTrip = 1'b1;
    @(negedge clk);
    @(negedge clk);
    senseTrip = 1'b0;
    countBlank(nb);
    begin
      int bad = 0;
      for (int i = 0; i < 15; i++) begin
        if (!srcLatch || decayFast || decaySlow) bad++;
        @(negedge clk);
      end
      check("R6 trip in blank ignored", bad, 0);
    end
    // held trip across blank end
    blankLong = 1'b0;
    senseTrip = 1'b1;
    waitOff();
    while (!blanking) @(negedge clk);
    countBlank(nb);
    check("R6 held trip re-enters off", decaySlow && !srcLatch, 1);
    senseTrip = 1'b0;
    while (!blanking) @(negedge clk);
    countBlank(nb);
  endtask

  // R7 R9
  task automatic testRestart();
    int nb;
    blankLong = 1'b0;
    decaySel = 2'b01;
    waitOn();
    dirIn = ~dirIn;
    @(negedge clk);
    check("R7 dir restart in on", blanking, 1);
    countBlank(nb);
    check("R7 restart blank length", nb, 6);
    senseTrip = 1'b1;
    waitOff();
    senseTrip = 1'b0;
    repeat (5) @(negedge clk);
    dirIn = ~dirIn;
    @(negedge clk);
    check("R7 dir restart in off", blanking && !decayFast && !decaySlow, 1);
    countBlank(nb);
    check("R7 off restart blank length", nb, 6);
    repeat (3) @(negedge clk);
    dirIn = ~dirIn;
    @(negedge clk);
    repeat (2) @(negedge clk);
    dirIn = ~dirIn;
    @(negedge clk);
    countBlank(nb);
    check("R7 restart mid-blank length", nb, 6);
    waitOn();
    enableIn = 1'b0;
    @(negedge clk);
    check("R7 enable fall restarts", blanking, 1);
    check("R9 drive off when disabled", srcDrive, 0);
    countBlank(nb);
    check("R9 latch set while disabled", srcLatch, 1);
    check("R9 drive still off", srcDrive, 0);
    enableIn = 1'b1;
    @(negedge clk);
    check("R7 enable rise restarts", blanking, 1);
    check("R9 drive follows latch", srcDrive, 1);
    countBlank(nb);
  endtask

  // R8
  task automatic testSr();
    int nb;
    decaySel = 2'b00;
    srEn = 1'b1;
    waitOn();
    senseTrip = 1'b1;
    waitOff();
    senseTrip = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 gate on in decay", srGate, 1);
    zeroDetect = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 gate off after zero", srGate, 0);
    zeroDetect = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 gate stays off", srGate, 0);
    check("R8 still decaying", decaySlow, 1);
    while (!blanking) @(negedge clk);
    countBlank(nb);
    senseTrip = 1'b1;
    waitOff();
    senseTrip = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 gate re-armed next off", srGate, 1);
    srEn = 1'b0;
    @(negedge clk);
    check("R8 gate off without srEn", srGate, 0);
    while (!blanking) @(negedge clk);
    countBlank(nb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testChop(2'b00, 0, 1'b0);
    testChop(2'b01, 14, 1'b0);
    testChop(2'b10, 46, 1'b1);
    testChop(2'b11, 96, 1'b0);
    testBlankIgnore();
    testRestart();
    testSr();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule